// File: doc/BRIEF.md
# Keyboard Snapshot I2C Target

This block is an I2C target that gives a host processor read access to a small register space describing a key matrix. The target answers at 7-bit address 0x15. It samples SCL and SDA with a fast system clock, and it finds START and STOP conditions itself. It ACKs or NACKs at the bit level and pulls SDA low through an open-drain enable. It never drives SDA high.

The register space holds 16 bytes. Two fixed identification bytes sit at the bottom and two reserved zero bytes follow them. Twelve bytes, one per key-matrix column, follow those. A scan engine elsewhere on the chip writes all twelve column bytes in one cycle with a load strobe. A read transfer always starts at register 0 after a STOP and steps forward by one register per byte. The host never writes a pointer.

Bytes the host writes do not go into the register space. They are appended to a separate 16-entry command buffer. Its contents and fill count are presented on ports for the command consumer. A STOP empties the count and rewinds the read pointer. The block works at standard-mode 100 kHz when the system clock is much faster than SCL. It does not stretch the clock.

Top module: `i2c_keyreg_target`

## Requirements
- R1: The target ACKs an address byte whose upper seven bits are 0x15 (0x2A for write, 0x2B for read). Any other address gets no ACK, and the target leaves SDA released for the rest of that transfer.
- R2: After reset, `sda_oe_o` is 0 and `cmd_len_o` is 0. Register 0 reads 0xAA and register 1 reads 0x55. Registers 2 and 3 always read 0x00. Registers 4 to 15 read 0x00 until the first snapshot load.
- R3: A one-cycle `snap_load_i` copies `snap_data_i[8k+7:8k]` into register 4+k, for k from 0 to 11.
- R4: Each byte read returns the register at the read pointer, most significant bit first, and then advances the pointer by one.
- R5: Once the read pointer has reached 16, every further byte read returns 0xFF.
- R6: Each byte written after a matching write address is ACKed. If the buffer holds fewer than 16 entries, the byte is stored at entry `cmd_len_o` (bits `cmd_buf_o[8k+7:8k]` for entry k) and `cmd_len_o` rises by one.
- R7: Written bytes that arrive while the buffer holds 16 entries are still ACKed but are dropped. `cmd_len_o` stays at 16 and stored entries are unchanged.
- R8: A STOP condition (SDA rising while SCL is high) resets the read pointer and `cmd_len_o` to 0.
- R9: A repeated START (SDA falling while SCL is high, with no STOP before it) does not move the read pointer.
- R10: When the host NACKs a read byte, the target releases SDA and keeps it released until the next START.
- R11: `sda_oe_o` changes only while the synchronized SCL is low. SDA is only ever pulled low, never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| snap_load_i | input | 1 | Strobe that captures the key snapshot |
| snap_data_i | input | 96 | Twelve column bytes, column k in bits 8k+7:8k |
| cmd_buf_o | output | 128 | Sixteen command bytes, entry k in bits 8k+7:8k |
| cmd_len_o | output | 5 | Number of stored command bytes, 0 to 16 |

## Verification
A read pointer stuck or off by one shows up at once as the wrong byte in the first or second read data phase. A pointer that does not saturate shows up as a non-0xFF byte after the sixteenth read. A wrong bit counter or shift register shows up within one byte time: the ACK lands on the wrong SCL pulse, or the read byte comes out shifted. A command length that does not saturate or clear shows up on `cmd_len_o` within a few system cycles of the byte's final SCL falling edge, or of the STOP. A mistimed open-drain enable shows up as an SDA transition while SCL is high, which the host would see as a false START or STOP.

// File: rtl/i2c_kr_pkg.sv
package i2c_kr_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ID_BYTE0 = 8'hAA;
    localparam logic [BYTE_W-1:0] ID_BYTE1 = 8'h55;
    localparam logic [BYTE_W-1:0] PAST_END = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WR,
        ST_ACK_W,
        ST_RD,
        ST_RD_ACK
    } bus_st_e;

    // Value of the fixed bytes below the snapshot area.
    function automatic logic [BYTE_W-1:0] fixed_reg(input int idx);
        case (idx)
            0:       return ID_BYTE0;
            1:       return ID_BYTE1;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_kr_sync.sv
module i2c_kr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    // Idle bus level is high, so every stage resets to 1.
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_kr_engine.sv
module i2c_kr_engine
    import i2c_kr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              rd_pop_o,
    output logic              wr_push_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              bus_stop_o,
    output logic              sda_oe_o
);
    typedef struct packed {
        bus_st_e           st;
        logic [BYTE_W-1:0] shreg;
        logic [3:0]        cnt;
        logic              rw;
        logic              nack;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
    } eng_t;

    eng_t eng_d, eng_q;
    logic scl_rise, scl_fall, start_c, stop_c;

    always_comb begin
        eng_d      = eng_q;
        rd_pop_o   = 1'b0;
        wr_push_o  = 1'b0;
        bus_stop_o = 1'b0;
        scl_rise   = scl_s & ~eng_q.scl_p;
        scl_fall   = ~scl_s & eng_q.scl_p;
        start_c    = scl_s & eng_q.scl_p & eng_q.sda_p & ~sda_s;
        stop_c     = scl_s & eng_q.scl_p & ~eng_q.sda_p & sda_s;
        eng_d.scl_p = scl_s;
        eng_d.sda_p = sda_s;

        if (stop_c) begin
            eng_d.st   = ST_IDLE;
            eng_d.oe   = 1'b0;
            bus_stop_o = 1'b1;
        end else if (start_c) begin
            eng_d.st  = ST_ADDR;
            eng_d.cnt = '0;
            eng_d.oe  = 1'b0;
        end else begin
            case (eng_q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise) begin
                        eng_d.shreg = {eng_q.shreg[BYTE_W-2:0], sda_s};
                        eng_d.cnt   = eng_q.cnt + 4'd1;
                    end else if (scl_fall && eng_q.cnt == 4'd8) begin
                        if (eng_q.st == ST_ADDR) begin
                            if (eng_q.shreg[7:1] == DEV_ADDR) begin
                                eng_d.st = ST_ACK_A;
                                eng_d.oe = 1'b1;
                                eng_d.rw = eng_q.shreg[0];
                            end else begin
                                eng_d.st = ST_IDLE;
                            end
                        end else begin
                            wr_push_o = 1'b1;
                            eng_d.st  = ST_ACK_W;
                            eng_d.oe  = 1'b1;
                        end
                    end
                end
                ST_ACK_A, ST_ACK_W: begin
                    if (scl_fall) begin
                        eng_d.cnt = '0;
                        if (eng_q.st == ST_ACK_A && eng_q.rw) begin
                            rd_pop_o    = 1'b1;
                            eng_d.shreg = rd_data_i;
                            eng_d.oe    = ~rd_data_i[BYTE_W-1];
                            eng_d.st    = ST_RD;
                        end else begin
                            eng_d.oe = 1'b0;
                            eng_d.st = ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (eng_q.cnt == 4'd7) begin
                            eng_d.oe = 1'b0;
                            eng_d.st = ST_RD_ACK;
                        end else begin
                            eng_d.shreg = {eng_q.shreg[BYTE_W-2:0], 1'b0};
                            eng_d.oe    = ~eng_q.shreg[BYTE_W-2];
                            eng_d.cnt   = eng_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        eng_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (!eng_q.nack) begin
                            rd_pop_o    = 1'b1;
                            eng_d.shreg = rd_data_i;
                            eng_d.oe    = ~rd_data_i[BYTE_W-1];
                            eng_d.cnt   = '0;
                            eng_d.st    = ST_RD;
                        end else begin
                            eng_d.oe = 1'b0;
                            eng_d.st = ST_IDLE;
                        end
                    end
                end
                default: eng_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, shreg: '0, cnt: '0, rw: 1'b0, nack: 1'b0,
                       oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign wr_data_o = eng_q.shreg;
    assign sda_oe_o  = eng_q.oe;
endmodule

// File: rtl/i2c_kr_regs.sv
module i2c_kr_regs
    import i2c_kr_pkg::*;
#(
    parameter int REG_N  = 16,
    parameter int SNAP_N = 12,
    parameter int CMD_N  = 16,
    localparam int PTR_W = $clog2(REG_N + 1),
    localparam int LEN_W = $clog2(CMD_N + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     snap_load_i,
    input  logic [SNAP_N*BYTE_W-1:0] snap_data_i,
    input  logic                     rd_pop_i,
    input  logic                     wr_push_i,
    input  logic [BYTE_W-1:0]        wr_data_i,
    input  logic                     bus_stop_i,
    output logic [BYTE_W-1:0]        rd_data_o,
    output logic [CMD_N*BYTE_W-1:0]  cmd_buf_o,
    output logic [LEN_W-1:0]         cmd_len_o
);
    localparam int SNAP_BASE = REG_N - SNAP_N;

    typedef struct {
        logic [BYTE_W-1:0] snap [SNAP_N];
        logic [BYTE_W-1:0] cmd  [CMD_N];
        logic [PTR_W-1:0]  ptr;
        logic [LEN_W-1:0]  len;
    } regs_t;

    regs_t rf_d, rf_q;

    always_comb begin
        rd_data_o = PAST_END;
        if (int'(rf_q.ptr) < SNAP_BASE) begin
            rd_data_o = fixed_reg(int'(rf_q.ptr));
        end else begin
            for (int k = 0; k < SNAP_N; k++) begin
                if (int'(rf_q.ptr) == SNAP_BASE + k) rd_data_o = rf_q.snap[k];
            end
        end
    end

    always_comb begin
        rf_d = rf_q;
        if (snap_load_i) begin
            for (int k = 0; k < SNAP_N; k++) begin
                rf_d.snap[k] = snap_data_i[BYTE_W*k +: BYTE_W];
            end
        end
        if (bus_stop_i) begin
            rf_d.ptr = '0;
            rf_d.len = '0;
        end else begin
            if (rd_pop_i && int'(rf_q.ptr) < REG_N) rf_d.ptr = rf_q.ptr + 1'b1;
            if (wr_push_i && int'(rf_q.len) < CMD_N) begin
                for (int k = 0; k < CMD_N; k++) begin
                    if (int'(rf_q.len) == k) rf_d.cmd[k] = wr_data_i;
                end
                rf_d.len = rf_q.len + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SNAP_N; k++) rf_q.snap[k] <= '0;
            for (int k = 0; k < CMD_N; k++)  rf_q.cmd[k]  <= '0;
            rf_q.ptr <= '0;
            rf_q.len <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    for (genvar g = 0; g < CMD_N; g++) begin : g_cmd_out
        assign cmd_buf_o[BYTE_W*g +: BYTE_W] = rf_q.cmd[g];
    end
    assign cmd_len_o = rf_q.len;
endmodule

// File: rtl/i2c_keyreg_target.sv
module i2c_keyreg_target
    import i2c_kr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h15,
    parameter int REG_N  = 16,
    parameter int SNAP_N = 12,
    parameter int CMD_N  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe_o,
    input  logic                        snap_load_i,
    input  logic [SNAP_N*8-1:0]         snap_data_i,
    output logic [CMD_N*8-1:0]          cmd_buf_o,
    output logic [$clog2(CMD_N+1)-1:0]  cmd_len_o
);
    logic              scl_s, sda_s;
    logic              rd_pop, wr_push, bus_stop;
    logic [BYTE_W-1:0] rd_data, wr_data;

    i2c_kr_sync #(.W(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  ({scl_s, sda_s})
    );

    i2c_kr_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .rd_data_i  (rd_data),
        .rd_pop_o   (rd_pop),
        .wr_push_o  (wr_push),
        .wr_data_o  (wr_data),
        .bus_stop_o (bus_stop),
        .sda_oe_o   (sda_oe_o)
    );

    i2c_kr_regs #(.REG_N(REG_N), .SNAP_N(SNAP_N), .CMD_N(CMD_N)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .snap_load_i (snap_load_i),
        .snap_data_i (snap_data_i),
        .rd_pop_i    (rd_pop),
        .wr_push_i   (wr_push),
        .wr_data_i   (wr_data),
        .bus_stop_i  (bus_stop),
        .rd_data_o   (rd_data),
        .cmd_buf_o   (cmd_buf_o),
        .cmd_len_o   (cmd_len_o)
    );
endmodule

// File: rtl/i2c_keyreg_target_chk.sv
module i2c_keyreg_target_chk #(
    parameter int CMD_N = 16,
    localparam int LEN_W = $clog2(CMD_N + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             bus_stop,
    input logic [LEN_W-1:0] cmd_len
);
    // R11: the pull-down enable may only move while SCL is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R7: the fill count never exceeds the buffer depth
    assert_len_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cmd_len) <= CMD_N);

    // R6: the fill count only steps up by one or clears
    assert_len_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_len) |-> (cmd_len == '0 || cmd_len == $past(cmd_len) + 1'b1));

    // R8: a STOP empties the command count on the next cycle
    assert_stop_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> cmd_len == '0);
endmodule

bind i2c_keyreg_target i2c_keyreg_target_chk #(.CMD_N(CMD_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .bus_stop (bus_stop),
    .cmd_len  (cmd_len_o)
);

// File: tb/i2c_keyreg_target_tb.sv
module i2c_keyreg_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;            // system cycles per quarter SCL period
    localparam int NVEC = 4;
    // {snapshot seed, number of bytes to read}
    localparam logic [12:0] VECS [NVEC] = '{
        {8'h3C, 5'd18}, {8'hA5, 5'd16}, {8'h00, 5'd5}, {8'hF0, 5'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_oe;
    logic        snap_load = 1'b0;
    logic [95:0] snap_data = '0;
    logic [127:0] cmd_buf;
    logic [4:0]  cmd_len;
    logic        sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int oe_viol = 0;
    bit done = 1'b0;

    assign sda_line = host_sda & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_keyreg_target u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (host_scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .snap_load_i (snap_load),
        .snap_data_i (snap_data),
        .cmd_buf_o   (cmd_buf),
        .cmd_len_o   (cmd_len)
    );

    // R11 monitor: look just after each edge, when outputs have settled
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && sda_oe != oe_prev && host_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; hold();
        host_scl = 1'b1; hold();
        host_sda = 1'b0; hold();
        host_scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; hold();
        host_scl = 1'b1; hold();
        host_sda = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        host_sda = b; hold();
        host_scl = 1'b1; hold(); hold();
        host_scl = 1'b0; hold();
    endtask

    task automatic recv_bit(output logic b);
        host_sda = 1'b1; hold();
        host_scl = 1'b1; hold();
        b = sda_line; hold();
        host_scl = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~ack);
    endtask

    function automatic logic [7:0] snap_byte(input logic [7:0] seed, input int k);
        return seed ^ 8'(k * 17);
    endfunction

    function automatic logic [7:0] exp_reg(input logic [7:0] seed, input int idx);
        if (idx == 0) return 8'hAA;
        if (idx == 1) return 8'h55;
        if (idx < 4) return 8'h00;
        if (idx < 16) return snap_byte(seed, idx - 4);
        return 8'hFF;
    endfunction

    task automatic load_snap(input logic [7:0] seed);
        @(negedge clk);
        for (int k = 0; k < 12; k++) snap_data[8*k +: 8] = snap_byte(seed, k);
        snap_load = 1'b1;
        @(negedge clk);
        snap_load = 1'b0;
    endtask

    initial begin
        logic       ack;
        logic [7:0] v;
        logic       b;

        repeat (5) @(negedge clk);
        // R2: reset state at the ports
        check("R2 oe after reset", {31'd0, sda_oe}, 32'd0);
        check("R2 len after reset", {27'd0, cmd_len}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: register contents before any snapshot load
        bus_start();
        send_byte(8'h2B, ack);
        check("R1 read address ack", {31'd0, ack}, 32'd1);
        for (int i = 0; i < 5; i++) begin
            recv_byte(i < 4, v);
            check("R2 reset register", {24'd0, v}, {24'd0, exp_reg(8'h00, i)});
        end
        bus_stop();

        // R3 R4 R5 R8: table of snapshots and read lengths
        for (int t = 0; t < NVEC; t++) begin
            logic [7:0] seed;
            int nrd;
            seed = VECS[t][12:5];
            nrd  = int'(VECS[t][4:0]);
            load_snap(seed);
            bus_start();
            send_byte(8'h2B, ack);
            check("R1 read address ack", {31'd0, ack}, 32'd1);
            for (int i = 0; i < nrd; i++) begin
                recv_byte(i < nrd - 1, v);
                if (i >= 16)
                    check("R5 past-end byte", {24'd0, v}, 32'hFF);
                else if (i >= 4)
                    check("R3 R4 snapshot byte", {24'd0, v}, {24'd0, exp_reg(seed, i)});
                else
                    check("R4 R8 fixed byte", {24'd0, v}, {24'd0, exp_reg(seed, i)});
            end
            bus_stop();
        end

        // R1: foreign address is not acknowledged, SDA stays released
        bus_start();
        send_byte(8'h2C, ack);
        check("R1 foreign address nack", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack);
        check("R1 no ack after mismatch", {31'd0, ack}, 32'd0);
        bus_stop();
        check("R1 mismatch no command", {27'd0, cmd_len}, 32'd0);

        // R6: three written bytes land in the buffer
        bus_start();
        send_byte(8'h2A, ack);
        check("R1 write address ack", {31'd0, ack}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'h11 * (i + 1), ack);
            check("R6 data ack", {31'd0, ack}, 32'd1);
        end
        check("R6 length", {27'd0, cmd_len}, 32'd3);
        check("R6 entry0", {24'd0, cmd_buf[7:0]}, 32'h11);
        check("R6 entry2", {24'd0, cmd_buf[23:16]}, 32'h33);
        bus_stop();
        repeat (4) @(negedge clk);
        check("R8 length cleared by stop", {27'd0, cmd_len}, 32'd0);

        // R7: overflow keeps the first sixteen bytes
        bus_start();
        send_byte(8'h2A, ack);
        for (int i = 0; i < 18; i++) begin
            send_byte(8'(i * 3 + 1), ack);
            if (i >= 16) check("R7 overflow byte acked", {31'd0, ack}, 32'd1);
        end
        check("R7 length saturates", {27'd0, cmd_len}, 32'd16);
        check("R7 last entry kept", {24'd0, cmd_buf[127:120]}, 32'd46);
        check("R7 first entry kept", {24'd0, cmd_buf[7:0]}, 32'd1);
        bus_stop();

        // R10 R9: NACK releases SDA, repeated START keeps the pointer
        load_snap(8'h6E);
        bus_start();
        send_byte(8'h2B, ack);
        recv_byte(1'b1, v);
        check("R4 first byte", {24'd0, v}, 32'hAA);
        recv_byte(1'b0, v);
        check("R4 second byte", {24'd0, v}, 32'h55);
        for (int i = 0; i < 3; i++) begin
            recv_bit(b);
            check("R10 released after nack", {31'd0, b}, 32'd1);
        end
        bus_start();
        send_byte(8'h2B, ack);
        check("R9 ack after repeated start", {31'd0, ack}, 32'd1);
        recv_byte(1'b1, v);
        check("R9 pointer kept (reg2)", {24'd0, v}, 32'h00);
        recv_byte(1'b1, v);
        check("R9 reg3", {24'd0, v}, 32'h00);
        recv_byte(1'b0, v);
        check("R9 reg4", {24'd0, v}, {24'd0, snap_byte(8'h6E, 0)});
        bus_stop();

        // R8: after STOP the next read begins at register 0
        bus_start();
        send_byte(8'h2B, ack);
        recv_byte(1'b0, v);
        check("R8 pointer rewound", {24'd0, v}, 32'hAA);
        bus_stop();

        repeat (4) @(negedge clk);
        check("R11 oe moved only while SCL low", oe_viol, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule